// File: doc/BRIEF.md
# Selectable PRBS Source with Bit-Error Injection

This block produces a pseudo-random test pattern for a serial receiver under test. At run time it can switch between four maximal-length sequences of different lengths. On request it corrupts single bits at a programmable average rate, which lets the bit-error counter at the far end be checked against a known error ratio.

The transmit path runs from a half-rate clock. On each enabled clock the block therefore emits two consecutive bits of the sequence on a pair of lanes. An external 2:1 serializer sends lane 0 first and lane 1 second. Alongside the lanes come two one-cycle pulses. One marks the cycle that carries a deliberately flipped bit. The other marks the cycle in which the sequence wraps back to its starting state. The pattern select and the rate select may change at any time without a reset.

Top module: `prbs_src`

## Requirements
- R1: While reset is low and in the first cycle after it, `lane_o` reads 2'b00 and `err_inj_o` and `restart_o` read 0.
- R2: `pat_sel` picks the generator polynomial. Code 0 is x^7+x^6+1, code 1 is x^15+x^14+1, code 2 is x^23+x^18+1 and code 3 is x^31+x^28+1. For order N with inner tap M, each step shifts the N-bit register left by one. The new bit 0 is the XOR of register bit N-1 and bit M-1, and that new bit is the output bit of the step. The seed is all ones.
- R3: Each enabled clock advances the generator by two steps. The bit of the first step appears on `lane_o[0]` and the bit of the second step on `lane_o[1]`, one clock after the edge that computed them.
- R4: When `pat_sel` differs from the value taken at the previous enabled edge, the generator restarts from the all-ones seed of the new order. The pair produced on that edge is the first two bits of the new sequence. This also recovers an all-zero register.
- R5: With `rate_sel` = 3 no bit is flipped, so the lanes carry the pure sequence and `err_inj_o` stays 0.
- R6: `rate_sel` codes 0, 1 and 2 flip one bit per I bits. I is ERR_INT_E3, ERR_INT_E6 or ERR_INT_E9 respectively, and the defaults are 1000, 1000000 and 1000000000. Every interval must be even and at least 4. Flips fall on every (I/2)-th enabled cycle, counted from the first enabled cycle after reset or after a rate change.
- R7: `err_inj_o` is 1 in exactly the cycle whose lane pair differs from the pure sequence, and that pair differs in exactly one bit.
- R8: Successive flips alternate between lanes. The first flip after reset or after a rate change lands on lane 0.
- R9: A change of `rate_sel` clears the bit count, so counting restarts from zero on that edge.
- R10: `restart_o` is a one-cycle pulse on the pair during which the register passes through its seed state again. A reload from a `pat_sel` change does not raise it.
- R11: While `en` is 0 the generator and error counter do not advance, `lane_o` holds its value, and both pulses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Advance enable |
| pat_sel | input | 2 | Sequence order select |
| rate_sel | input | 2 | Error-rate select |
| lane_o | output | 2 | Bit pair, lane 0 sent first |
| err_inj_o | output | 1 | Pair carries a flipped bit |
| restart_o | output | 1 | Sequence wrapped to its seed |

## Verification
A corrupted generator register shows as a lane mismatch against the reference sequence within one clock, because every pair is compared. A wrong error counter or lane pointer shows as a flip that lands on the wrong cycle or the wrong lane. Short interval overrides make that visible within a few tens of cycles, and a missing flip surfaces one interval later. A fault in seed detection shows as a missing or misplaced restart pulse at the 64th cycle of the 7-bit sequence.

// File: rtl/prbs_src_pkg.sv
package prbs_src_pkg;

    localparam int LFSR_W = 31;

    typedef enum logic [1:0] {
        ORD_7  = 2'd0,
        ORD_15 = 2'd1,
        ORD_23 = 2'd2,
        ORD_31 = 2'd3
    } order_e;

    typedef enum logic [1:0] {
        RATE_E3  = 2'd0,
        RATE_E6  = 2'd1,
        RATE_E9  = 2'd2,
        RATE_OFF = 2'd3
    } rate_e;

    typedef enum logic {
        ERR_IDLE  = 1'b0,
        ERR_COUNT = 1'b1
    } err_state_e;

    typedef enum logic {
        GEN_SEED = 1'b0,
        GEN_RUN  = 1'b1
    } gen_state_e;

    function automatic logic [4:0] ord_msb(order_e o);
        logic [4:0] r;
        unique case (o)
            ORD_7:   r = 5'd6;
            ORD_15:  r = 5'd14;
            ORD_23:  r = 5'd22;
            default: r = 5'd30;
        endcase
        return r;
    endfunction

    function automatic logic [4:0] ord_tap(order_e o);
        logic [4:0] r;
        unique case (o)
            ORD_7:   r = 5'd5;
            ORD_15:  r = 5'd13;
            ORD_23:  r = 5'd17;
            default: r = 5'd27;
        endcase
        return r;
    endfunction

    function automatic logic [LFSR_W-1:0] ord_mask(order_e o);
        logic [LFSR_W-1:0] m;
        m = '1;
        return m >> (5'd30 - ord_msb(o));
    endfunction

    function automatic logic [LFSR_W-1:0] lfsr_adv(logic [LFSR_W-1:0] s, order_e o);
        logic fb;
        fb = s[ord_msb(o)] ^ s[ord_tap(o)];
        return {s[LFSR_W-2:0], fb} & ord_mask(o);
    endfunction

endpackage

// File: rtl/prbs_lfsr2.sv
module prbs_lfsr2
    import prbs_src_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  order_e     order_i,
    output logic [1:0] pair_o,
    output logic       wrap_o
);
    logic [LFSR_W-1:0] state_q;
    order_e            order_q;
    gen_state_e        mode;
    logic [LFSR_W-1:0] seed, cur, s1, s2;

    always_comb begin
        seed = ord_mask(order_i);
        mode = (order_i != order_q) ? GEN_SEED : GEN_RUN;
        unique case (mode)
            GEN_SEED: cur = seed;
            GEN_RUN:  cur = state_q;
            default:  cur = seed;
        endcase
        s1     = lfsr_adv(cur, order_i);
        s2     = lfsr_adv(s1, order_i);
        pair_o = {s2[0], s1[0]};
        wrap_o = (s1 == seed) || (s2 == seed);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ord_mask(ORD_7);
            order_q <= ORD_7;
        end else if (en) begin
            state_q <= s2;
            order_q <= order_i;
        end
    end
endmodule

// File: rtl/prbs_err_sched.sv
module prbs_err_sched
    import prbs_src_pkg::*;
#(
    parameter int unsigned INT_E3 = 1000,
    parameter int unsigned INT_E6 = 1000000,
    parameter int unsigned INT_E9 = 1000000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  rate_e      rate_i,
    output logic [1:0] flip_o
);
    localparam int unsigned MAX_A = (INT_E3 > INT_E6) ? INT_E3 : INT_E6;
    localparam int unsigned MAX_I = (MAX_A > INT_E9) ? MAX_A : INT_E9;
    localparam int CNT_W = $clog2(MAX_I + 1);

    err_state_e       state_q, state_d;
    rate_e            rate_q;
    logic [CNT_W-1:0] cnt_q, cnt_base;
    logic             lane_q, lane_base, rate_chg, hit;
    logic [31:0]      interval, next_cnt;

    always_comb begin
        rate_chg  = (rate_i != rate_q);
        unique case (rate_i)
            RATE_E3: interval = 32'(INT_E3);
            RATE_E6: interval = 32'(INT_E6);
            RATE_E9: interval = 32'(INT_E9);
            default: interval = 32'd0;
        endcase
        cnt_base  = (rate_chg || state_q == ERR_IDLE) ? '0 : cnt_q;
        lane_base = rate_chg ? 1'b0 : lane_q;
        next_cnt  = 32'(cnt_base) + 32'd2;
        state_d   = (rate_i == RATE_OFF) ? ERR_IDLE : ERR_COUNT;
        hit       = (state_d == ERR_COUNT) && (next_cnt >= interval);
        flip_o    = (hit && en) ? (lane_base ? 2'b10 : 2'b01) : 2'b00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ERR_IDLE;
            rate_q  <= RATE_OFF;
            cnt_q   <= '0;
            lane_q  <= 1'b0;
        end else if (en) begin
            state_q <= state_d;
            rate_q  <= rate_i;
            unique case (state_d)
                ERR_IDLE: begin
                    cnt_q  <= '0;
                    lane_q <= 1'b0;
                end
                ERR_COUNT: begin
                    cnt_q  <= hit ? '0 : CNT_W'(next_cnt);
                    lane_q <= hit ? ~lane_base : lane_base;
                end
                default: cnt_q <= '0;
            endcase
        end
    end
endmodule

// File: rtl/prbs_out_stage.sv
module prbs_out_stage (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] pair_i,
    input  logic [1:0] flip_i,
    input  logic       wrap_i,
    output logic [1:0] lane_o,
    output logic       err_o,
    output logic       wrap_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_o <= 2'b00;
            err_o  <= 1'b0;
            wrap_o <= 1'b0;
        end else if (en) begin
            lane_o <= pair_i ^ flip_i;
            err_o  <= |flip_i;
            wrap_o <= wrap_i;
        end else begin
            err_o  <= 1'b0;
            wrap_o <= 1'b0;
        end
    end
endmodule

// File: rtl/prbs_src.sv
module prbs_src
    import prbs_src_pkg::*;
#(
    parameter int unsigned ERR_INT_E3 = 1000,
    parameter int unsigned ERR_INT_E6 = 1000000,
    parameter int unsigned ERR_INT_E9 = 1000000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] pat_sel,
    input  logic [1:0] rate_sel,
    output logic [1:0] lane_o,
    output logic       err_inj_o,
    output logic       restart_o
);
    logic [1:0] pair, flip;
    logic       wrap;

    prbs_lfsr2 u_gen (
        .clk(clk), .rst_n(rst_n), .en(en),
        .order_i(order_e'(pat_sel)),
        .pair_o(pair), .wrap_o(wrap)
    );

    prbs_err_sched #(
        .INT_E3(ERR_INT_E3), .INT_E6(ERR_INT_E6), .INT_E9(ERR_INT_E9)
    ) u_err (
        .clk(clk), .rst_n(rst_n), .en(en),
        .rate_i(rate_e'(rate_sel)),
        .flip_o(flip)
    );

    prbs_out_stage u_out (
        .clk(clk), .rst_n(rst_n), .en(en),
        .pair_i(pair), .flip_i(flip), .wrap_i(wrap),
        .lane_o(lane_o), .err_o(err_inj_o), .wrap_o(restart_o)
    );
endmodule

// File: rtl/prbs_src_chk.sv
module prbs_src_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic [1:0] rate_sel,
    input logic [1:0] lane_o,
    input logic       err_inj_o,
    input logic       restart_o
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (lane_o == 2'b00 && !err_inj_o && !restart_o)); // R1

    AST_NO_FLIP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rate_sel == 2'd3) |=> !err_inj_o); // R5

    AST_FLIP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        err_inj_o |=> !err_inj_o); // R6

    AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |=> !restart_o); // R10

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(rst_n)) |=> ($stable(lane_o) && !err_inj_o && !restart_o)); // R11
endmodule

bind prbs_src prbs_src_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .rate_sel(rate_sel),
    .lane_o(lane_o), .err_inj_o(err_inj_o), .restart_o(restart_o)
);

// File: tb/prbs_src_test.sv
module prbs_src_test;
    localparam int CLK_PERIOD = 10;
    localparam int IA = 16, IB = 40, IC = 100;

    logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
    logic [1:0] pat_sel = 2'd0, rate_sel = 2'd3;
    logic [1:0] lane_o;
    logic err_inj_o, restart_o;
    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prbs_src #(.ERR_INT_E3(IA), .ERR_INT_E6(IB), .ERR_INT_E9(IC)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .pat_sel(pat_sel), .rate_sel(rate_sel),
        .lane_o(lane_o), .err_inj_o(err_inj_o), .restart_o(restart_o));

    // reference model state
    bit [30:0] m_reg;
    int        m_ord;
    int        m_rate, m_cnt, m_lane;
    bit [1:0]  e_lane;
    bit        e_err, e_wrap;
    int        flag_count, wrap_count;

    function automatic int len_of(int c);
        return (c == 0) ? 7 : (c == 1) ? 15 : (c == 2) ? 23 : 31;
    endfunction
    function automatic int tap_of(int c);
        return (c == 0) ? 6 : (c == 1) ? 14 : (c == 2) ? 18 : 28;
    endfunction
    function automatic bit [30:0] seed_of(int c);
        bit [30:0] s = '0;
        for (int i = 0; i < len_of(c); i++) s[i] = 1'b1;
        return s;
    endfunction
    function automatic int interval_of(int r);
        return (r == 0) ? IA : (r == 1) ? IB : IC;
    endfunction

    task automatic model_bit(output bit b);
        int n = len_of(m_ord);
        int t = tap_of(m_ord);
        b = m_reg[n-1] ^ m_reg[t-1];
        m_reg = ((m_reg << 1) | 31'(b)) & seed_of(m_ord);
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(bit e, int ps, int rs);
        bit b0, b1, w;
        bit [1:0] fl;
        en = e; pat_sel = 2'(ps); rate_sel = 2'(rs);
        if (e) begin
            if (ps != m_ord) begin m_ord = ps; m_reg = seed_of(ps); end // R4
            model_bit(b0); w = (m_reg == seed_of(m_ord));
            model_bit(b1); w = w || (m_reg == seed_of(m_ord));
            fl = 2'b00;
            if (rs != m_rate) begin m_rate = rs; m_cnt = 0; m_lane = 0; end // R9
            if (rs != 3) begin
                if (m_cnt + 2 >= interval_of(rs)) begin
                    fl = m_lane ? 2'b10 : 2'b01;
                    m_lane = 1 - m_lane; m_cnt = 0;
                end else m_cnt += 2;
            end else begin m_cnt = 0; m_lane = 0; end
            e_lane = {b1, b0} ^ fl; e_err = |fl; e_wrap = w;
        end else begin
            e_err = 0; e_wrap = 0;
        end
        @(posedge clk);
        @(negedge clk);
        check("R2/R3 lanes", lane_o, e_lane);
        check("R6/R7/R8 err flag", err_inj_o, e_err);
        check("R10 restart", restart_o, e_wrap);
        if (err_inj_o) flag_count++;
        if (restart_o) wrap_count++;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(1234));
        m_ord = 0; m_reg = seed_of(0); m_rate = 3; m_cnt = 0; m_lane = 0;
        e_lane = 0;
        repeat (3) @(negedge clk);
        check("R1 reset lanes", lane_o, 0);
        check("R1 reset err", err_inj_o, 0);
        check("R1 reset restart", restart_o, 0);
        rst_n = 1'b1;

        // R5 R10: pure 7-bit sequence, wraps at cycles 64,127,191,254
        flag_count = 0; wrap_count = 0;
        for (int i = 0; i < 254; i++) step(1, 0, 3);
        check("R5 no flips when off", flag_count, 0);
        check("R10 wrap count", wrap_count, 4);

        // R2 R4: every order, reload on change
        for (int o = 3; o >= 0; o--)
            for (int i = 0; i < 80; i++) step(1, o, 3);

        // R6 R8: short interval flags every IA/2 cycles, alternating lanes
        flag_count = 0;
        for (int i = 0; i < 8 * 12; i++) step(1, 1, 0);
        check("R6 flips per 96 cycles at I=16", flag_count, 12);

        // R9: rate change restarts count
        flag_count = 0;
        for (int i = 0; i < 19; i++) step(1, 1, 1);
        step(1, 1, 2);
        for (int i = 0; i < 48; i++) step(1, 1, 2);
        check("R9 no flip before new interval", flag_count, 0);
        step(1, 1, 2);
        check("R9 flip at 50th cycle", flag_count, 1);

        // R11: enable low holds
        for (int i = 0; i < 5; i++) step(0, 2, 0);
        step(1, 1, 2);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int ps = int'(pat_sel), rs = int'(rate_sel);
            bit e = ($urandom_range(0, 9) != 0);
            if ($urandom_range(0, 199) == 0) ps = $urandom_range(0, 3);
            if ($urandom_range(0, 99) == 0) rs = $urandom_range(0, 3);
            step(e, ps, rs);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule